// File: doc/BRIEF.md
# Bus Ownership Semaphore

This block decides who may drive a single SMBus host controller when two agents share it: software on the host CPU, and an embedded microcontroller on the same die. At most one of them owns the controller at any time. The owner keeps it until it lets go.

Software reaches the semaphore through one byte-wide control register, located at a fixed offset inside the controller's register window. To ask for the bus, software writes a 1 into the request bit. It then reads that same bit back: a 1 means the bus is now its own, and a 0 means the request was refused. Software gives the bus back by writing a 1 into a separate release bit.

The microcontroller uses two dedicated inputs. One is a request level that it holds high while it wants the bus. The other is a one-cycle release strobe. The microcontroller sees its grant on its own output. A busy output shows that either side holds the bus. A refused software request is remembered, so it is granted as soon as the microcontroller lets go.

Top module: `bus_sema`

## Requirements
- R1: The control register is decoded only at `reg_addr_i == REG_OFF` (default 8). Reads at any other address return 0, and writes at any other address have no effect on ownership.
- R2: When the bus is free and the microcontroller is not requesting, a write with bit 4 = 1 gives the bus to the host. From the next cycle, bit 4 reads as 1 and `busy_o` is 1.
- R3: A write with bit 5 = 1 releases host ownership, and bit 4 reads 0 from the next cycle. Bit 5 always reads 0. When bits 4 and 5 are both written as 1, the release wins.
- R4: When the bus is free, `ec_req_i` = 1 raises `ec_grant_o` in the next cycle. A one-cycle `ec_rel_i` frees the bus in the next cycle.
- R5: While the microcontroller owns the bus, a host request is refused and bit 4 reads 0. Repeated requests are refused in the same way.
- R6: When the bus is free and both sides request in the same cycle, the microcontroller is granted.
- R7: A grant persists until its owner releases it. Requests from the other side, and `ec_rel_i` while the host owns the bus, do not change the owner.
- R8: When the owner releases while the other side has a request outstanding (the microcontroller's `ec_req_i` is high, or a refused host request is pending), the other side owns the bus from the next cycle. No new request is needed.
- R9: Writing 0 to bit 4 has no effect. It does not request the bus when it is free, and it does not drop ownership.
- R10: `busy_o` is 1 exactly when either side holds the grant.
- R11: A host release write clears a pending, refused host request. When the microcontroller then releases, the bus becomes free.
- R12: During and directly after reset the bus is free: bit 4 reads 0, and `ec_grant_o` and `busy_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe, one cycle per write |
| reg_addr_i | input | ADDR_W | Register byte offset within the controller window |
| reg_wdata_i | input | DATA_W | Write data: bit 4 requests, bit 5 releases |
| reg_rdata_o | output | DATA_W | Read data: bit 4 = host owns the bus, all other bits 0 |
| ec_req_i | input | 1 | Microcontroller ownership request, held as a level |
| ec_rel_i | input | 1 | Microcontroller release strobe |
| ec_grant_o | output | 1 | Microcontroller owns the bus |
| busy_o | output | 1 | Either side owns the bus |

## Verification
The block's state is small: an owner code and one pending flag. Any error in it shows at the ports one cycle after the edge that caused it. A wrong owner appears at once in read bit 4, in `ec_grant_o` and in `busy_o`. A pending flag that is lost, or one that is not cleared, stays hidden until the microcontroller releases. The sequences therefore always follow a refused or cancelled host request with a microcontroller release, and then check which side owns the bus in the cycle after that release.

// File: rtl/bus_sema_pkg.sv
package bus_sema_pkg;
  localparam int unsigned REQ_BIT = 4;
  localparam int unsigned REL_BIT = 5;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_HOST = 2'd1,
    OWN_EC   = 2'd2
  } owner_e;
endpackage

// File: rtl/bus_sema_regif.sv
module bus_sema_regif
  import bus_sema_pkg::*;
#(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned REG_OFF = 8
) (
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              host_owns_i,
  output logic              req_wr_o,
  output logic              rel_wr_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [ADDR_W-1:0] OFF = ADDR_W'(REG_OFF);

  logic hit;
  logic unused_wdata;

  assign hit          = (addr_i == OFF);
  assign req_wr_o     = we_i && hit && wdata_i[REQ_BIT];
  assign rel_wr_o     = we_i && hit && wdata_i[REL_BIT];
  assign unused_wdata = ^wdata_i;

  // release bit is write-only, reads back 0
  always_comb begin
    rdata_o = '0;
    if (hit) rdata_o[REQ_BIT] = host_owns_i;
  end
endmodule

// File: rtl/bus_sema_arb.sv
module bus_sema_arb
  import bus_sema_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   host_req_wr_i,
  input  logic   host_rel_wr_i,
  input  logic   ec_req_i,
  input  logic   ec_rel_i,
  output owner_e owner_o
);
  owner_e owner_q, owner_d;
  logic   host_pend_q, host_pend_d;
  logic   host_want;

  // release in the same write overrides request
  assign host_want = (host_pend_q | host_req_wr_i) & ~host_rel_wr_i;

  always_comb begin
    owner_d = owner_q;
    unique case (owner_q)
      OWN_NONE: begin
        if (ec_req_i)       owner_d = OWN_EC;   // EC wins ties
        else if (host_want) owner_d = OWN_HOST;
      end
      OWN_HOST: if (host_rel_wr_i) owner_d = ec_req_i  ? OWN_EC   : OWN_NONE;
      OWN_EC:   if (ec_rel_i)      owner_d = host_want ? OWN_HOST : OWN_NONE;
      default:  owner_d = OWN_NONE;
    endcase
    host_pend_d = host_want && (owner_q != OWN_HOST) && (owner_d != OWN_HOST);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q     <= OWN_NONE;
      host_pend_q <= 1'b0;
    end else begin
      owner_q     <= owner_d;
      host_pend_q <= host_pend_d;
    end
  end

  assign owner_o = owner_q;

  AST_HOST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_HOST && !host_rel_wr_i) |=> (owner_q == OWN_HOST)); // R7
  AST_EC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_EC && !ec_rel_i) |=> (owner_q == OWN_EC)); // R7
  AST_EC_TIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_NONE && ec_req_i) |=> (owner_q == OWN_EC)); // R6
  AST_HANDOFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_EC && ec_rel_i && host_pend_q && !host_rel_wr_i) |=> (owner_q == OWN_HOST)); // R8
  AST_NO_PEND_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_HOST) |-> !host_pend_q); // R11
endmodule

// File: rtl/bus_sema.sv
module bus_sema
  import bus_sema_pkg::*;
#(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned REG_OFF = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              ec_req_i,
  input  logic              ec_rel_i,
  output logic              ec_grant_o,
  output logic              busy_o
);
  owner_e owner;
  logic   req_wr, rel_wr;

  bus_sema_regif #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .REG_OFF(REG_OFF)
  ) u_regif (
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .host_owns_i(owner == OWN_HOST),
    .req_wr_o   (req_wr),
    .rel_wr_o   (rel_wr),
    .rdata_o    (reg_rdata_o)
  );

  bus_sema_arb u_arb (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .host_req_wr_i(req_wr),
    .host_rel_wr_i(rel_wr),
    .ec_req_i     (ec_req_i),
    .ec_rel_i     (ec_rel_i),
    .owner_o      (owner)
  );

  assign ec_grant_o = (owner == OWN_EC);
  assign busy_o     = (owner != OWN_NONE);
endmodule

// File: tb/bus_sema_test.sv
module bus_sema_test;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [3:0] addr = 4'd8;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       ec_req = 1'b0;
  logic       ec_rel = 1'b0;
  logic       ec_grant;
  logic       busy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    string      tag;
    logic [7:0] rd;
    logic       ecg;
    logic       bsy;
  } exp_t;

  exp_t exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  bus_sema uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .reg_we_i   (we),
    .reg_addr_i (addr),
    .reg_wdata_i(wdata),
    .reg_rdata_o(rdata),
    .ec_req_i   (ec_req),
    .ec_rel_i   (ec_rel),
    .ec_grant_o (ec_grant),
    .busy_o     (busy)
  );

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  // drive one cycle of stimulus, queue what the ports must show after the edge
  task automatic cyc(logic w, logic [3:0] a, logic [7:0] d, logic er, logic el,
                     logic [7:0] e_rd, logic e_ecg, logic e_bsy, string tag);
    exp_t e;
    @(negedge clk);
    we = w; addr = a; wdata = d; ec_req = er; ec_rel = el;
    e.tag = tag; e.rd = e_rd; e.ecg = e_ecg; e.bsy = e_bsy;
    exp_q.push_back(e);
  endtask

  // monitor: compare a quarter period after each rising edge
  always @(posedge clk) begin
    #(CLK_P/4);
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk(e.tag, "rdata", rdata, e.rd);
      chk(e.tag, "ec_grant", {7'd0, ec_grant}, {7'd0, e.ecg});
      chk({e.tag, "/R10"}, "busy", {7'd0, busy}, {7'd0, e.bsy});
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12", "rdata in reset", rdata, 8'h00);
    chk("R12", "ec_grant in reset", {7'd0, ec_grant}, 8'h00);
    chk("R12", "busy in reset", {7'd0, busy}, 8'h00);
    rst_n = 1'b1;

    cyc(0, 8, 8'h00, 0, 0, 8'h00, 0, 0, "R12");
    cyc(1, 8, 8'h10, 0, 0, 8'h10, 0, 1, "R2");
    cyc(1, 8, 8'h00, 0, 0, 8'h10, 0, 1, "R9");
    cyc(0, 8, 8'h00, 1, 0, 8'h10, 0, 1, "R7");
    cyc(1, 8, 8'h20, 1, 0, 8'h00, 1, 1, "R8");
    cyc(1, 8, 8'h10, 1, 0, 8'h00, 1, 1, "R5");
    cyc(1, 8, 8'h10, 1, 0, 8'h00, 1, 1, "R5");
    cyc(0, 8, 8'h00, 1, 0, 8'h00, 1, 1, "R7");
    cyc(0, 8, 8'h00, 0, 1, 8'h10, 0, 1, "R8");
    cyc(1, 8, 8'h20, 0, 0, 8'h00, 0, 0, "R3");
    cyc(1, 8, 8'h10, 1, 0, 8'h00, 1, 1, "R6");
    cyc(1, 8, 8'h20, 1, 0, 8'h00, 1, 1, "R11");
    cyc(0, 8, 8'h00, 0, 1, 8'h00, 0, 0, "R11");
    cyc(0, 8, 8'h00, 1, 0, 8'h00, 1, 1, "R4");
    cyc(0, 8, 8'h00, 0, 1, 8'h00, 0, 0, "R4");
    cyc(1, 8, 8'h00, 0, 0, 8'h00, 0, 0, "R9");
    cyc(1, 9, 8'h10, 0, 0, 8'h00, 0, 0, "R1");
    cyc(0, 8, 8'h00, 0, 0, 8'h00, 0, 0, "R1");
    cyc(1, 8, 8'h10, 0, 0, 8'h10, 0, 1, "R2");
    cyc(0, 3, 8'h00, 0, 0, 8'h00, 0, 1, "R1");
    cyc(1, 2, 8'h20, 0, 0, 8'h00, 0, 1, "R1");
    cyc(0, 8, 8'h00, 0, 0, 8'h10, 0, 1, "R1");
    cyc(1, 8, 8'h30, 0, 0, 8'h00, 0, 0, "R3");
    cyc(1, 8, 8'h30, 0, 0, 8'h00, 0, 0, "R3");
    cyc(1, 8, 8'h10, 0, 0, 8'h10, 0, 1, "R2");
    cyc(0, 8, 8'h00, 0, 1, 8'h10, 0, 1, "R7");
    cyc(1, 8, 8'hFF, 0, 0, 8'h00, 0, 0, "R3");
    cyc(0, 8, 8'h00, 0, 0, 8'h00, 0, 0, "R3");

    @(negedge clk);
    we = 1'b0; ec_req = 1'b0; ec_rel = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule